// File: doc/BRIEF.md
# Boot Console Mailbox Register Block

This block is a small memory-mapped window that a booting processor shares with a platform console service. The processor uses it to learn boot parameters, to start a block-device read, to send and receive terminal characters, and to leave a start stack for each secondary processor. The boot parameters are CPU count, interrupt and CPU clock rates, memory size and kernel addresses. The bus side takes one request at a time. Each request carries a byte offset, a byte count of 4 or 8, a write flag and 64-bit write data. The block answers with a one-cycle response that carries read data and a status bit, where OK is 0 and ERROR is 1.

Boot parameters enter on plain configuration pins and are read live. The disk engine sits behind a plain ready/start handshake. The terminal sits behind two byte streams that use valid/ready. A byte moves only in a cycle where both valid and ready are high. The output stream keeps valid high and its data stable until ready is seen. The block raises input ready for one cycle and takes a byte only if valid is high in that cycle. A back-pressured output stream or a disk port that is not ready delays the response. Nothing is lost.

Top module: `boot_mailbox`

## Requirements
- R1: After reset, offset 0x00 (4-byte) reads 0x26F, 0x04 (4-byte) reads 1305, 0x38 (8-byte) reads 1, and the 8-byte locations 0x40, 0x48, 0x50, 0x58, 0x60 and every stack slot read 0.
- R2: 4-byte reads at 0x08 and 0x0C return the CPU count and the interrupt clock, zero-extended. 8-byte reads at 0x10, 0x18, 0x20, 0x28 and 0x30 return the CPU clock, memory size, kernel start, kernel end and entry point. All of these values come from the configuration pins.
- R3: These reads return ERROR with data 0: a 4-byte read at any offset other than 0x00, 0x04, 0x08 or 0x0C, an 8-byte access at an offset that is not a multiple of 8, and an 8-byte access below 0x10 or above 0x268.
- R4: A request whose byte count is neither 4 nor 8 returns ERROR and changes no state.
- R5: A 4-byte write, or an 8-byte write to a read-only location (0x00 to 0x30, or 0x68), returns ERROR and leaves every readable value unchanged.
- R6: Writing 0x13 to 0x58 raises disk_start for exactly one cycle, and only in a cycle where disk_ready is high. In that cycle disk_addr, disk_block and disk_count carry the values stored at 0x48, 0x50 and 0x40, and 0x58 then reads 0x13. Any other value written to 0x58 returns ERROR, gives no pulse and stores nothing.
- R7: An 8-byte write to 0x60 offers write-data bits [7:0] on the output byte stream. The byte stays offered with stable data until it is accepted, and the response waits for that acceptance. 0x60 then reads that byte zero-extended.
- R8: An 8-byte read of 0x68 takes one byte from the input stream and returns it zero-extended. When the stream offers nothing, the read returns 0 and consumes nothing.
- R9: Stack slot n (0 to 63) is at 0x70 + 8n and can be read and written with 8-byte accesses. Writing 0 to a slot returns ERROR and leaves the slot unchanged.
- R10: When no stream or disk stall occurs, rsp_valid rises exactly RSP_LAT cycles after the accepting clock edge and lasts one cycle. req_ready is low from acceptance until the response has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_bytes | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Status: 0 OK, 1 ERROR |
| rsp_rdata | output | 64 | Read data, 0 on error or write |
| cfg_num_cpus | input | 32 | CPU count |
| cfg_intr_hz | input | 32 | Interrupt clock in Hz |
| cfg_cpu_mhz | input | 64 | CPU clock in MHz |
| cfg_mem_size | input | 64 | Memory size |
| cfg_kern_start | input | 64 | Kernel start address |
| cfg_kern_end | input | 64 | Kernel end address |
| cfg_entry | input | 64 | Kernel entry point |
| disk_ready | input | 1 | Disk engine can take a start |
| disk_start | output | 1 | One-cycle disk read start |
| disk_addr | output | 64 | Stored destination physical address |
| disk_block | output | 64 | Stored starting block |
| disk_count | output | 64 | Stored block count |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Output stream accepts |
| out_data | output | 8 | Output byte |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Block takes the input byte |
| in_data | input | 8 | Input byte |

## Verification
Reads are tried on every fixed field, on both ends of the stack slot range and at illegal offsets, sizes and alignments. This separates the width decode from the offset decode. Writes go to writable, read-only and just-out-of-range locations and are each followed by a read-back, which shows whether an error left state untouched. The output and disk paths are run once with the far side ready and once stalled for several cycles, which separates the fixed latency from stalls. Input reads are made both with bytes queued and with an empty stream, which tells consumption apart from the return of 0.

// File: rtl/boot_mailbox_pkg.sv
package boot_mailbox_pkg;

  localparam int OFS_LAST   = 'h00;
  localparam int OFS_VER    = 'h04;
  localparam int OFS_NCPU   = 'h08;
  localparam int OFS_IHZ    = 'h0C;
  localparam int OFS_CMHZ   = 'h10;
  localparam int OFS_MEM    = 'h18;
  localparam int OFS_KSTART = 'h20;
  localparam int OFS_KEND   = 'h28;
  localparam int OFS_ENTRY  = 'h30;
  localparam int OFS_DUNIT  = 'h38;
  localparam int OFS_DCNT   = 'h40;
  localparam int OFS_DADDR  = 'h48;
  localparam int OFS_DBLK   = 'h50;
  localparam int OFS_DOP    = 'h58;
  localparam int OFS_OUTC   = 'h60;
  localparam int OFS_INC    = 'h68;
  localparam int OFS_SLOT0  = 'h70;

  localparam logic [63:0] DISK_READ_CMD = 64'h13;

  typedef enum logic [4:0] {
    F_NONE, F_LAST, F_VER, F_NCPU, F_IHZ, F_CMHZ, F_MEM, F_KSTART,
    F_KEND, F_ENTRY, F_DUNIT, F_DCNT, F_DADDR, F_DBLK, F_DOP,
    F_OUTC, F_INC, F_SLOT
  } field_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_EXEC, ST_WAIT, ST_RESP
  } mb_state_e;

endpackage

// File: rtl/bmb_decode.sv
module bmb_decode
  import boot_mailbox_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_SLOTS = 64,
  parameter int SLOT_W    = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        bytes,
  input  logic              wr,
  input  logic [63:0]       wdata,
  output field_e            fld,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              err
);

  localparam logic [ADDR_W-1:0] A_SLOT0 = ADDR_W'(OFS_SLOT0);
  localparam logic [ADDR_W-1:0] A_SLOTN = ADDR_W'(OFS_SLOT0 + 8 * (NUM_SLOTS - 1));

  logic [ADDR_W-1:0] soff;
  assign soff = addr - A_SLOT0;

  always_comb begin
    fld      = F_NONE;
    err      = 1'b0;
    slot_idx = '0;
    if (bytes == 4'd4) begin
      // narrow window: read-only, four fixed words
      if (wr) err = 1'b1;
      case (addr)
        ADDR_W'(OFS_LAST): fld = F_LAST;
        ADDR_W'(OFS_VER):  fld = F_VER;
        ADDR_W'(OFS_NCPU): fld = F_NCPU;
        ADDR_W'(OFS_IHZ):  fld = F_IHZ;
        default:           err = 1'b1;
      endcase
    end else if (bytes == 4'd8) begin
      if (addr[2:0] != 3'b000) begin
        err = 1'b1;
      end else if (addr >= A_SLOT0 && addr <= A_SLOTN) begin
        fld      = F_SLOT;
        slot_idx = soff[3 +: SLOT_W];
      end else begin
        case (addr)
          ADDR_W'(OFS_CMHZ):   fld = F_CMHZ;
          ADDR_W'(OFS_MEM):    fld = F_MEM;
          ADDR_W'(OFS_KSTART): fld = F_KSTART;
          ADDR_W'(OFS_KEND):   fld = F_KEND;
          ADDR_W'(OFS_ENTRY):  fld = F_ENTRY;
          ADDR_W'(OFS_DUNIT):  fld = F_DUNIT;
          ADDR_W'(OFS_DCNT):   fld = F_DCNT;
          ADDR_W'(OFS_DADDR):  fld = F_DADDR;
          ADDR_W'(OFS_DBLK):   fld = F_DBLK;
          ADDR_W'(OFS_DOP):    fld = F_DOP;
          ADDR_W'(OFS_OUTC):   fld = F_OUTC;
          ADDR_W'(OFS_INC):    fld = F_INC;
          default:             err = 1'b1;
        endcase
      end
      if (!err && wr) begin
        case (fld)
          F_DUNIT, F_DCNT, F_DADDR, F_DBLK, F_OUTC: ;
          F_DOP:   if (wdata != DISK_READ_CMD) err = 1'b1;
          F_SLOT:  if (wdata == 64'd0) err = 1'b1;
          default: err = 1'b1;
        endcase
      end
    end else begin
      err = 1'b1;
    end
  end

endmodule

// File: rtl/bmb_regs.sv
module bmb_regs
  import boot_mailbox_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  parameter int SLOT_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  field_e            fld,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [63:0]       wdata,
  output logic [63:0]       dunit,
  output logic [63:0]       dcnt,
  output logic [63:0]       daddr,
  output logic [63:0]       dblk,
  output logic [63:0]       dop,
  output logic [63:0]       outc,
  output logic [63:0]       slot_rd
);

  logic [NUM_SLOTS-1:0][63:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dunit <= 64'd1;
      dcnt  <= '0;
      daddr <= '0;
      dblk  <= '0;
      dop   <= '0;
      outc  <= '0;
    end else if (wr_en) begin
      case (fld)
        F_DUNIT: dunit <= wdata;
        F_DCNT:  dcnt  <= wdata;
        F_DADDR: daddr <= wdata;
        F_DBLK:  dblk  <= wdata;
        F_DOP:   dop   <= wdata;
        F_OUTC:  outc  <= {56'd0, wdata[7:0]};
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (wr_en && fld == F_SLOT && slot_idx == SLOT_W'(g))
        slot_q[g] <= wdata;
    end
  end

  assign slot_rd = slot_q[slot_idx];

  AST_SLOT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fld == F_SLOT) |-> (wdata != 64'd0)); // R9

  AST_UNIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dunit) && $stable(dop)); // R5

endmodule

// File: rtl/bmb_ctrl.sv
module bmb_ctrl
  import boot_mailbox_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int RSP_LAT = 3,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_bytes,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [3:0]        lat_bytes,
  output logic              lat_wr,
  output logic [63:0]       lat_wdata,
  input  field_e            fld,
  input  logic              dec_err,
  input  logic [63:0]       rd_data,
  output logic              wr_en,
  input  logic              disk_ready,
  output logic              disk_start,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              in_ready
);

  mb_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic             go;
  logic             is_out, is_disk, is_in;

  always_comb begin
    is_out  = (st == ST_EXEC) && !dec_err && lat_wr && fld == F_OUTC;
    is_disk = (st == ST_EXEC) && !dec_err && lat_wr && fld == F_DOP;
    is_in   = (st == ST_EXEC) && !dec_err && !lat_wr && fld == F_INC;
    go      = (st == ST_EXEC) &&
              !(is_out && !out_ready) && !(is_disk && !disk_ready);
  end

  assign out_valid  = is_out;
  assign out_data   = lat_wdata[7:0];
  assign disk_start = is_disk && disk_ready;
  assign in_ready   = is_in;
  assign wr_en      = go && lat_wr && !dec_err;
  assign req_ready  = (st == ST_IDLE);
  assign rsp_valid  = (st == ST_RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      lat_addr  <= '0;
      lat_bytes <= '0;
      lat_wr    <= 1'b0;
      lat_wdata <= '0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          lat_addr  <= req_addr;
          lat_bytes <= req_bytes;
          lat_wr    <= req_write;
          lat_wdata <= req_wdata;
          st        <= ST_EXEC;
        end
        ST_EXEC: if (go) begin
          rsp_err   <= dec_err;
          rsp_rdata <= (dec_err || lat_wr) ? 64'd0 : rd_data;
          cnt       <= CNT_W'(RSP_LAT - 2);
          st        <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt == '0) st <= ST_RESP;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // checker-only counters: cycles since acceptance and stalled cycles
  logic [15:0] chk_age, chk_stall;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_age   <= '0;
      chk_stall <= '0;
    end else if (st == ST_IDLE) begin
      chk_age   <= '0;
      chk_stall <= '0;
    end else begin
      chk_age <= chk_age + 16'd1;
      if (st == ST_EXEC && !go) chk_stall <= chk_stall + 16'd1;
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (chk_age - chk_stall) == 16'(RSP_LAT)); // R10

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data)); // R7

  AST_DISK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    disk_start |=> !disk_start); // R6

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10

endmodule

// File: rtl/boot_mailbox.sv
module boot_mailbox
  import boot_mailbox_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_SLOTS = 64,
  parameter int RSP_LAT   = 3,
  parameter int VERSION   = 1305
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_bytes,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata,
  input  logic [31:0]       cfg_num_cpus,
  input  logic [31:0]       cfg_intr_hz,
  input  logic [63:0]       cfg_cpu_mhz,
  input  logic [63:0]       cfg_mem_size,
  input  logic [63:0]       cfg_kern_start,
  input  logic [63:0]       cfg_kern_end,
  input  logic [63:0]       cfg_entry,
  input  logic              disk_ready,
  output logic              disk_start,
  output logic [63:0]       disk_addr,
  output logic [63:0]       disk_block,
  output logic [63:0]       disk_count,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data
);

  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int LAST_OFF = OFS_SLOT0 + 8 * NUM_SLOTS - 1;
  localparam int CNT_W    = (RSP_LAT > 2) ? $clog2(RSP_LAT) + 1 : 1;

  logic [ADDR_W-1:0] lat_addr;
  logic [3:0]        lat_bytes;
  logic              lat_wr;
  logic [63:0]       lat_wdata;
  field_e            fld;
  logic [SLOT_W-1:0] slot_idx;
  logic              dec_err;
  logic              wr_en;
  logic [63:0]       rd_data;
  logic [63:0]       dunit, dop, outc, slot_rd;

  bmb_ctrl #(.ADDR_W(ADDR_W), .RSP_LAT(RSP_LAT), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .lat_addr(lat_addr), .lat_bytes(lat_bytes), .lat_wr(lat_wr),
    .lat_wdata(lat_wdata), .fld(fld), .dec_err(dec_err), .rd_data(rd_data),
    .wr_en(wr_en), .disk_ready(disk_ready), .disk_start(disk_start),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .in_ready(in_ready)
  );

  bmb_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_dec (
    .addr(lat_addr), .bytes(lat_bytes), .wr(lat_wr), .wdata(lat_wdata),
    .fld(fld), .slot_idx(slot_idx), .err(dec_err)
  );

  bmb_regs #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .fld(fld), .slot_idx(slot_idx),
    .wdata(lat_wdata), .dunit(dunit), .dcnt(disk_count), .daddr(disk_addr),
    .dblk(disk_block), .dop(dop), .outc(outc), .slot_rd(slot_rd)
  );

  always_comb begin
    case (fld)
      F_LAST:   rd_data = 64'(LAST_OFF);
      F_VER:    rd_data = 64'(VERSION);
      F_NCPU:   rd_data = {32'd0, cfg_num_cpus};
      F_IHZ:    rd_data = {32'd0, cfg_intr_hz};
      F_CMHZ:   rd_data = cfg_cpu_mhz;
      F_MEM:    rd_data = cfg_mem_size;
      F_KSTART: rd_data = cfg_kern_start;
      F_KEND:   rd_data = cfg_kern_end;
      F_ENTRY:  rd_data = cfg_entry;
      F_DUNIT:  rd_data = dunit;
      F_DCNT:   rd_data = disk_count;
      F_DADDR:  rd_data = disk_addr;
      F_DBLK:   rd_data = disk_block;
      F_DOP:    rd_data = dop;
      F_OUTC:   rd_data = outc;
      F_INC:    rd_data = in_valid ? {56'd0, in_data} : 64'd0;
      F_SLOT:   rd_data = slot_rd;
      default:  rd_data = 64'd0;
    endcase
  end

  AST_IN_TAKE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready); // R8

endmodule

// File: tb/boot_mailbox_tb_top.sv
module boot_mailbox_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [9:0] req_addr = '0;
  logic [3:0] req_bytes = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic disk_ready = 1, disk_start;
  logic [63:0] disk_addr, disk_block, disk_count;
  logic out_valid, out_ready = 1;
  logic [7:0] out_data;
  logic in_valid = 0, in_ready;
  logic [7:0] in_data = '0;

  localparam logic [31:0] C_NCPU = 32'd4, C_IHZ = 32'd1024;
  localparam logic [63:0] C_CMHZ = 64'd2000, C_MEM = 64'h1_0000_0000;
  localparam logic [63:0] C_KS = 64'h20_0000, C_KE = 64'h80_0000, C_EP = 64'h20_1000;

  boot_mailbox #(.RSP_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_bytes(req_bytes),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .cfg_num_cpus(C_NCPU), .cfg_intr_hz(C_IHZ),
    .cfg_cpu_mhz(C_CMHZ), .cfg_mem_size(C_MEM), .cfg_kern_start(C_KS),
    .cfg_kern_end(C_KE), .cfg_entry(C_EP), .disk_ready(disk_ready),
    .disk_start(disk_start), .disk_addr(disk_addr), .disk_block(disk_block),
    .disk_count(disk_count), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data)
  );

  typedef struct {
    bit          err;
    logic [63:0] data;
    int          acc;
    bit          lat;
    string       tag;
  } item_t;

  item_t sb_q[$];
  logic [7:0] out_exp_q[$];
  logic [7:0] in_q[$];
  int n_chk = 0, n_bad = 0, cyc = 0, n_disk = 0;
  logic [63:0] exp_daddr = '0, exp_dblk = '0, exp_dcnt = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input bit w, input logic [9:0] a, input logic [3:0] b,
                      input logic [63:0] d, input bit eerr, input logic [63:0] edat,
                      input bit lchk, input string tag);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_bytes = b; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 0;
    it.err = eerr; it.data = edat; it.acc = cyc; it.lat = lchk; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic rd8(input logic [9:0] a, input logic [63:0] e, input string tag);
    send(0, a, 4'd8, 64'd0, 0, e, 1, tag);
  endtask

  task automatic wr8(input logic [9:0] a, input logic [63:0] d, input bit eerr,
                     input string tag);
    send(1, a, 4'd8, d, eerr, 64'd0, 1, tag);
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: response scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        check(0, "R10 response without request", 64'd1, 64'd0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(rsp_err == it.err, {it.tag, " status"}, 64'(rsp_err), 64'(it.err));
        if (!it.err && !it.lat) ;
        if (!it.err)
          check(rsp_rdata == it.data, {it.tag, " data"}, rsp_rdata, it.data);
        if (it.lat)
          check(cyc - it.acc == LAT, "R10 latency", 64'(cyc - it.acc), 64'(LAT));
      end
    end
  end

  // monitor: disk start pulses
  always @(negedge clk) begin
    if (rst_n && disk_start) begin
      n_disk++;
      check(disk_ready === 1'b1, "R6 start without ready", 64'(disk_ready), 64'd1);
      check({disk_addr, disk_block, disk_count} == {exp_daddr, exp_dblk, exp_dcnt},
            "R6 disk parameters", disk_addr ^ disk_block ^ disk_count,
            exp_daddr ^ exp_dblk ^ exp_dcnt);
    end
  end

  // monitor: output stream
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (out_exp_q.size() == 0)
        check(0, "R7 unexpected output byte", 64'(out_data), 64'd0);
      else begin
        logic [7:0] e;
        e = out_exp_q.pop_front();
        check(out_data == e, "R7 output byte", 64'(out_data), 64'(e));
      end
    end
  end

  // input stream source
  initial begin
    forever begin
      bit tk;
      @(negedge clk);
      tk = in_valid && in_ready;
      @(posedge clk); #1;
      if (tk) void'(in_q.pop_front());
      in_valid = (in_q.size() != 0);
      in_data  = (in_q.size() != 0) ? in_q[0] : 8'h00;
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(req_ready == 1 && rsp_valid == 0 && disk_start == 0 && out_valid == 0,
          "R1 idle outputs after reset", 64'({req_ready, rsp_valid}), 64'b10);

    // R1 reset values
    send(0, 10'h000, 4'd4, 0, 0, 64'h26F, 1, "R1 last offset");
    send(0, 10'h004, 4'd4, 0, 0, 64'd1305, 1, "R1 version");
    rd8(10'h038, 64'd1, "R1 disk unit");
    rd8(10'h040, 64'd0, "R1 disk count");
    rd8(10'h048, 64'd0, "R1 disk addr");
    rd8(10'h050, 64'd0, "R1 disk block");
    rd8(10'h058, 64'd0, "R1 disk op");
    rd8(10'h060, 64'd0, "R1 out char");
    rd8(10'h070, 64'd0, "R1 slot 0");
    rd8(10'h268, 64'd0, "R1 slot 63");

    // R2 configuration reads
    send(0, 10'h008, 4'd4, 0, 0, 64'(C_NCPU), 1, "R2 cpu count");
    send(0, 10'h00C, 4'd4, 0, 0, 64'(C_IHZ), 1, "R2 intr clock");
    rd8(10'h010, C_CMHZ, "R2 cpu clock");
    rd8(10'h018, C_MEM, "R2 mem size");
    rd8(10'h020, C_KS, "R2 kernel start");
    rd8(10'h028, C_KE, "R2 kernel end");
    rd8(10'h030, C_EP, "R2 entry");

    // R3 decode errors
    send(0, 10'h010, 4'd4, 0, 1, 0, 1, "R3 narrow read wide field");
    send(0, 10'h000, 4'd8, 0, 1, 0, 1, "R3 wide read narrow field");
    send(0, 10'h014, 4'd8, 0, 1, 0, 1, "R3 misaligned wide read");
    send(0, 10'h270, 4'd8, 0, 1, 0, 1, "R3 past last slot");

    // R4 bad sizes
    send(0, 10'h038, 4'd2, 0, 1, 0, 1, "R4 two-byte read");
    send(1, 10'h038, 4'd1, 64'h55, 1, 0, 1, "R4 one-byte write");
    rd8(10'h038, 64'd1, "R4 unit unchanged");

    // R5 illegal writes
    wr8(10'h020, 64'h1234, 1, "R5 write kernel start");
    rd8(10'h020, C_KS, "R5 kernel start unchanged");
    wr8(10'h068, 64'h77, 1, "R5 write input char");
    send(1, 10'h038, 4'd4, 64'h9, 1, 0, 1, "R5 narrow write");
    rd8(10'h038, 64'd1, "R5 unit unchanged");
    wr8(10'h038, 64'd3, 0, "R5 unit write ok");
    rd8(10'h038, 64'd3, "R5 unit readback");

    // R6 disk
    exp_dcnt = 64'd5; exp_daddr = 64'h1000; exp_dblk = 64'd7;
    wr8(10'h040, exp_dcnt, 0, "R6 count write");
    wr8(10'h048, exp_daddr, 0, "R6 addr write");
    wr8(10'h050, exp_dblk, 0, "R6 block write");
    rd8(10'h048, exp_daddr, "R6 addr readback");
    drain();
    @(posedge clk); #1 disk_ready = 0;
    send(1, 10'h058, 4'd8, 64'h13, 0, 0, 0, "R6 start stalled");
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(n_disk == 0 && rsp_valid == 0, "R6 no start while not ready",
          64'(n_disk), 64'd0);
    @(posedge clk); #1 disk_ready = 1;
    drain();
    check(n_disk == 1, "R6 one pulse", 64'(n_disk), 64'd1);
    rd8(10'h058, 64'h13, "R6 op readback");
    wr8(10'h058, 64'h12, 1, "R6 bad command");
    rd8(10'h058, 64'h13, "R6 op unchanged");
    wr8(10'h058, 64'h13, 0, "R6 start ready");
    drain();
    check(n_disk == 2, "R6 second pulse", 64'(n_disk), 64'd2);

    // R7 output stream
    out_exp_q.push_back(8'h41);
    wr8(10'h060, 64'h1234_5641, 0, "R7 out write");
    drain();
    @(posedge clk); #1 out_ready = 0;
    out_exp_q.push_back(8'h7A);
    send(1, 10'h060, 4'd8, 64'hFF7A, 0, 0, 0, "R7 out stalled");
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1 && out_data == 8'h7A && rsp_valid == 0,
          "R7 byte held under stall", 64'(out_data), 64'h7A);
    @(posedge clk); #1 out_ready = 1;
    drain();
    check(out_exp_q.size() == 0, "R7 all bytes out", 64'(out_exp_q.size()), 64'd0);
    rd8(10'h060, 64'h7A, "R7 out readback");

    // R8 input stream
    in_q.push_back(8'h55);
    in_q.push_back(8'hAA);
    repeat (2) @(posedge clk);
    rd8(10'h068, 64'h55, "R8 first byte");
    rd8(10'h068, 64'hAA, "R8 second byte");
    rd8(10'h068, 64'h00, "R8 empty stream");
    drain();
    check(in_q.size() == 0, "R8 consumed", 64'(in_q.size()), 64'd0);

    // R9 stack slots
    wr8(10'h098, 64'hDEAD_BEEF_0000_0001, 0, "R9 slot 5 write");
    rd8(10'h098, 64'hDEAD_BEEF_0000_0001, "R9 slot 5 read");
    wr8(10'h098, 64'd0, 1, "R9 zero write");
    rd8(10'h098, 64'hDEAD_BEEF_0000_0001, "R9 slot 5 unchanged");
    wr8(10'h268, 64'hCAFE, 0, "R9 slot 63 write");
    rd8(10'h268, 64'hCAFE, "R9 slot 63 read");
    rd8(10'h0A0, 64'd0, "R9 slot 6 untouched");
    wr8(10'h270, 64'h1, 1, "R9 slot 64 write");
    drain();

    finish_run();
  end

endmodule